// File: doc/BRIEF.md
# Column Counter for a Coarse-Fine Time-Stretched Single-Slope Converter

This block holds the digital side of one column of a 10-bit hybrid single-slope converter. After a start request it counts fast clock cycles while the ramp runs, and it stops at the first cycle where the column comparator, after a two-flop synchronizer, reads high. That count is the upper six bits of the result. The converter then enters a fine phase. An analog stretcher outside this block widens the leftover fraction of a ramp clock period sixteen times and presents it as a pulse on `stretch_i`. The same fast clock counts the cycles of that pulse, which gives the lower four bits.

The block also drives a clock at one sixteenth of the conversion clock rate. The stretcher uses the falling edge of that clock to close its window. When the fine phase ends, the two counts are merged into one code and a one-cycle done flag is raised. A long stretched pulse means the comparator toggled early in its coarse period, so the fine count is subtracted from fifteen. If the comparator never toggles within the coarse range, the result saturates at full scale. The worst case is 80 cycles from start to done, where a plain single-slope count would need 1024.

Top module: `tsadc_column`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `div16_o` are low and `code_o` is zero.
- R2: `cmp_i` passes a two-flop synchronizer. The coarse count starts at zero on the start edge, adds one per COARSE cycle, and freezes on the first edge where the synchronized comparator is high. If `cmp_i` is raised k edges after the start edge, the coarse count is k+2 and it appears in `code_o[9:4]`.
- R3: In FINE, the fine count adds one for every edge where `stretch_i` is high and clamps at 15. FINE ends on the first low sample after a high one, or after 16 FINE cycles, whichever comes first. `stretch_i` has no effect outside FINE.
- R4: The result is `code_o = coarse*16 + (15 - fine)`.
- R5: If the synchronized comparator is not high within 64 COARSE cycles, `code_o` becomes 1023 and done comes 64 edges after the start edge.
- R6: `done_o` is high for exactly one cycle per conversion, and `code_o` is valid in that cycle. With the timing of R2/R3, done comes at most 80 edges after the start edge.
- R7: `start_i` is ignored whenever the block is not idle, including the done cycle. A start held high through a conversion does not change its result.
- R8: `div16_o` is bit 3 of a conversion-cycle counter that the start edge clears. It is high in cycles 8..15 after start, low in cycles 0..7, and falls every 16 cycles.
- R9: `code_o` keeps its value after done until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled only when idle |
| cmp_i | input | 1 | Column comparator output, asynchronous |
| stretch_i | input | 1 | Stretched residual-time pulse from the analog stretcher |
| div16_o | output | 1 | Conversion clock divided by 16 |
| busy_o | output | 1 | High in the coarse and fine phases |
| done_o | output | 1 | One-cycle completion flag |
| code_o | output | 10 | Merged conversion result |

## Verification
A coarse counter that freezes one cycle late or early moves `code_o[9:4]` by one step. A miscounted stretch sample moves the low nibble. Both show in the very next done cycle, and the done latency shifts with them. A window that never closes, or a lost comparator event, shows as done arriving at the wrong edge or as a saturated 1023. A start that leaks into a running conversion restarts the counters, and this is visible in `div16_o` within eight cycles and as a wrong code at done.

// File: rtl/tsadc_pkg.sv
package tsadc_pkg;
  localparam int unsigned DEF_COARSE_W   = 6;
  localparam int unsigned DEF_FINE_W     = 4;
  localparam int unsigned DEF_SYNC_STAGE = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COARSE = 2'd1,
    ST_FINE   = 2'd2,
    ST_DONE   = 2'd3
  } conv_state_e;
endpackage

// File: rtl/tsadc_sync.sv
module tsadc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tsadc_coarse.sv
module tsadc_coarse #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         hit_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_evt_o,
  output logic         sat_evt_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  assign hit_evt_o = run_i && hit_i;
  assign sat_evt_o = run_i && !hit_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt_q <= '0;
    else if (clear_i)                         cnt_q <= '0;
    else if (run_i && !hit_i && !sat_evt_o)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R2: the coarse count stays frozen once the comparator event is taken
  p_freeze_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt_o |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/tsadc_fine.sv
module tsadc_fine #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         run_i,
  input  logic         stretch_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         end_evt_o
);
  localparam logic [W-1:0] CNT_MAX  = '1;
  localparam logic [W-1:0] WIN_LAST = '1;

  logic [W-1:0] cnt_q, cnt_d, win_q;
  logic         seen_q;

  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)                cnt_d = '0;
    else if (run_i && stretch_i) cnt_d = sat_inc(cnt_q);
  end

  assign end_evt_o = run_i && ((seen_q && !stretch_i) || (win_q == WIN_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      win_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (clear_i) begin
        win_q  <= '0;
        seen_q <= 1'b0;
      end else if (run_i) begin
        win_q <= win_q + 1'b1;
        if (stretch_i) seen_q <= 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  // R3: a full fine count never wraps while the stretch pulse continues
  p_fine_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && stretch_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  // R3: outside the fine phase the stretch input leaves the count untouched
  p_fine_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tsadc_div16.sv
module tsadc_div16 #(
  parameter int unsigned W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic div_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign div_o = cnt_q[W-1];

  // R8: the divided clock falls right after the last count of a period
  p_div_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clear_i && cnt_q == TOP) |=> !div_o);
endmodule

// File: rtl/tsadc_column.sv
module tsadc_column
  import tsadc_pkg::*;
#(
  parameter int unsigned COARSE_W   = DEF_COARSE_W,
  parameter int unsigned FINE_W     = DEF_FINE_W,
  parameter int unsigned SYNC_STAGE = DEF_SYNC_STAGE
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         cmp_i,
  input  logic                         stretch_i,
  output logic                         div16_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic [COARSE_W+FINE_W-1:0]   code_o
);
  localparam int unsigned CODE_W = COARSE_W + FINE_W;
  localparam logic [CODE_W-1:0] CODE_FULL = '1;
  localparam logic [FINE_W-1:0] FINE_MAX  = '1;

  conv_state_e state_q, state_d;

  logic                cmp_sync;
  logic                start_evt, cmp_hit, coarse_sat, fine_end;
  logic [COARSE_W-1:0] coarse_cnt;
  logic [FINE_W-1:0]   fine_cnt, fine_nxt;
  logic [CODE_W-1:0]   code_q;

  function automatic logic [CODE_W-1:0] merge_code(
    input logic [COARSE_W-1:0] c, input logic [FINE_W-1:0] f);
    return {c, FINE_MAX - f};
  endfunction

  assign start_evt = start_i && (state_q == ST_IDLE);

  tsadc_sync #(.STAGES(SYNC_STAGE)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cmp_i), .sync_o(cmp_sync));

  tsadc_coarse #(.W(COARSE_W)) u_coarse (
    .clk(clk), .rst_n(rst_n), .clear_i(start_evt),
    .run_i(state_q == ST_COARSE), .hit_i(cmp_sync),
    .cnt_o(coarse_cnt), .hit_evt_o(cmp_hit), .sat_evt_o(coarse_sat));

  tsadc_fine #(.W(FINE_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .clear_i(start_evt),
    .run_i(state_q == ST_FINE), .stretch_i(stretch_i),
    .cnt_o(fine_cnt), .cnt_nxt_o(fine_nxt), .end_evt_o(fine_end));

  tsadc_div16 #(.W(FINE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clear_i(start_evt),
    .run_i(busy_o), .div_o(div16_o));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_evt)  state_d = ST_COARSE;
      ST_COARSE: if (cmp_hit)    state_d = ST_FINE;
                 else if (coarse_sat) state_d = ST_DONE;
      ST_FINE:   if (fine_end)   state_d = ST_DONE;
      ST_DONE:                   state_d = ST_IDLE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      if (coarse_sat)    code_q <= CODE_FULL;
      else if (fine_end) code_q <= merge_code(coarse_cnt, fine_nxt);
    end
  end

  assign busy_o = (state_q == ST_COARSE) || (state_q == ST_FINE);
  assign done_o = (state_q == ST_DONE);
  assign code_o = code_q;

  // R6: completion is flagged for a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R2: a taken comparator event leads into the fine phase
  p_hit_to_fine_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> (state_q == ST_FINE));

  // R5: a missing comparator toggle yields full scale at done
  p_sat_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_sat |=> (done_o && code_o == CODE_FULL));

  // R7: start during the fine phase does not restart the coarse phase
  p_start_fine_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_FINE) |=> (state_q != ST_COARSE));

  // R7: start during the done cycle does not chain into a new conversion
  p_start_done_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_DONE) |=> (state_q == ST_IDLE));

  // R9: the result changes only when a conversion completes
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!coarse_sat && !fine_end) |=> $stable(code_o));

  // R6: the fine phase always finishes with the counters holding a result
  p_fine_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINE && fine_end) |=> (done_o && code_o[FINE_W-1:0] == FINE_MAX - fine_cnt));
endmodule

// File: tb/tsadc_column_tb.sv
module tsadc_column_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       cmp_i = 1'b0;
  logic       stretch_i = 1'b0;
  logic       div16_o, busy_o, done_o;
  logic [9:0] code_o;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  // 50 MHz: 20-unit period
  always #10 clk = ~clk;

  tsadc_column dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .stretch_i(stretch_i), .div16_o(div16_o), .busy_o(busy_o),
    .done_o(done_o), .code_o(code_o));

  typedef struct packed {
    int k;     // edges after start before cmp_i rises
    int m;     // stretch pulse width in cycles
    int code;  // expected result
    int lat;   // expected edges from start to done
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{k: 0,  m: 0,  code: 47,   lat: 19},
    '{k: 0,  m: 15, code: 32,   lat: 19},
    '{k: 10, m: 5,  code: 202,  lat: 19},
    '{k: 20, m: 20, code: 352,  lat: 39},
    '{k: 61, m: 3,  code: 1020, lat: 68},
    '{k: 30, m: 1,  code: 526,  lat: 35},
    '{k: 5,  m: 14, code: 113,  lat: 23},
    '{k: 45, m: 8,  code: 759,  lat: 57},
    '{k: 61, m: 15, code: 1008, lat: 80}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // k < 0 means the comparator never toggles
  task automatic run_conv(input int k, input int m, input int exp_code, input int exp_lat,
                          input bit poke, input bit noise, input bit div_chk);
    int  n;
    int  lat;
    int  code;
    bit  got;
    lat = -1; code = -1; got = 1'b0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = poke;
    n = 0;
    cmp_i     = (k >= 0 && n >= k);
    stretch_i = (k >= 0 && n >= k + 3 && n < k + 3 + m) || (noise && n < k);
    while (!got && n < 200) begin
      @(negedge clk);
      n++;
      if (div_chk && n <= 60 && (n % 4) == 0)
        check(div16_o == ((n >> 3) & 1), "R8 divided clock level", int'(div16_o), (n >> 3) & 1);
      if (done_o) begin
        got  = 1'b1;
        lat  = n;
        code = int'(code_o);
        start_i = 1'b0;
      end else begin
        cmp_i     = (k >= 0 && n >= k);
        stretch_i = (k >= 0 && n >= k + 3 && n < k + 3 + m) || (noise && n < k);
      end
    end
    cmp_i = 1'b0; stretch_i = 1'b0; start_i = 1'b0;
    check(code == exp_code, "R4 merged code", code, exp_code);
    check(lat == exp_lat, "R6 done latency", lat, exp_lat);
    @(negedge clk);
    check(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
    check(busy_o == 1'b0, "R7 idle after done", int'(busy_o), 0);
    repeat (3) @(negedge clk);
    check(int'(code_o) == exp_code, "R9 code held", int'(code_o), exp_code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
    check(div16_o == 1'b0, "R1 div16 after reset", int'(div16_o), 0);
    check(code_o == 10'd0, "R1 code after reset", int'(code_o), 0);

    // R2 R3 R4 R6: table walk
    for (int i = 0; i < NV; i++) begin
      run_conv(VECS[i].k, VECS[i].m, VECS[i].code, VECS[i].lat, 1'b0, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
    end

    // R5 saturation, with R8 divided clock sampled along the way
    run_conv(-1, 0, 1023, 64, 1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);

    // R3 stretch pulses during the coarse phase are ignored
    run_conv(12, 6, 233, 22, 1'b0, 1'b1, 1'b0);
    repeat (2) @(negedge clk);

    // R7 start held high through a whole conversion
    run_conv(20, 4, 363, 28, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);

    // R2 coarse bits alone for a mid-range toggle
    run_conv(33, 2, 35 * 16 + 13, 39, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule